// File: doc/BRIEF.md
# Indirect Serial Flash Read Engine

This block fetches a run of bytes from a serial flash device into a local word buffer on a software command. The host first programs the start address, the number of bytes and the shape of the read instruction: opcode, number of data lanes, whether a mode byte follows the address, how many dummy clocks come next, and whether the address is three or four bytes long. It then sets the start bit. The engine sends the instruction beat by beat on a lane-level pin interface and assembles the returned bytes into 32-bit words in a small buffer.

The host does not have to wait for the read to finish. It polls a level register and pops words from a data port while the flash transfer is still running. When the buffer fills, the engine holds the flash clock until the host has made room. A control register reports busy and done. It also accepts a cancel, and done is cleared by writing a one to it. Each beat on the pin interface is marked by a strobe, and a separate timing stage outside this block turns the strobes into the serial clock.

Top module: `flash_indirect_reader`

## Requirements
- R1: After reset, chip select and the beat strobe are low, the control word (index 0) reads 0 and the level word (index 5) reads 0.
- R2: Setting control bit 0 while idle raises chip select and sends the 8 opcode bits (format bits 7:0) MSB first, one per strobe, on lane 0 with output enable 4'b0001. The address (index 1) follows MSB first on lane 0. It uses 4 bytes when the address-length field (format bits 17:16, bytes minus one) is 3, and 3 bytes (address bits 23:0) otherwise.
- R3: When format bit 10 is set, the 8-bit mode value (index 4, bits 7:0) is sent on lane 0 after the address. Then comes the number of dummy strobes given in format bits 15:11 (0 to 31), with all output enables low.
- R4: In the data phase the lane-width field (format bits 9:8) selects the lanes. Value 0 samples lane 1 over 8 strobes per byte. Value 1 samples lanes 1:0 over 4 strobes. Values 2 and 3 sample lanes 3:0 over 2 strobes. Bits arrive MSB first within each byte.
- R5: The first byte of each word lands in bits 7:0 and the fourth in bits 31:24. If the byte count (index 2) is not a multiple of four, the last word is zero-padded and counts as one word.
- R6: The level word (index 5, bits 15:0) gives the number of words buffered. Reading the data port (index 6) returns the oldest word and removes it, and this works while the read is still running.
- R7: While the buffer is full during the data phase, the beat strobe stays low and chip select stays high until a word is popped. No data is lost.
- R8: Control bit 2 reads 1 while a read is running. When the last word has entered the buffer, chip select drops and control bit 5 (done) becomes 1 with bit 2 at 0.
- R9: Writing a 1 to control bit 5 clears done. A control write with bit 5 at 0 leaves done unchanged.
- R10: Writing control bit 1 aborts the read. Chip select drops on the next clock, the buffer is emptied, and neither busy nor done remains set.
- R11: A start written while a read is running is ignored. A start with a byte count of 0 sets done without raising chip select.
- R12: Reading the data port while the buffer is empty returns 0 and leaves the level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; on index 6 it pops a word |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| flash_sel | output | 1 | Chip select, active high |
| flash_tick | output | 1 | A serial clock beat is taken this cycle |
| flash_io_out | output | 4 | Lane output values |
| flash_io_oe | output | 4 | Lane output enables |
| flash_io_in | input | 4 | Lane input values, sampled on beats of the data phase |

## Verification
The bench aims at phase boundaries. It uses a mode byte with a nonzero dummy count and a four-byte address, where a miscounted dummy field shifts every returned byte by a few bits. It drives inverted data on the unused lanes, so sampling the wrong lane produces visibly wrong words. Byte counts of 1, 5 and 7 test the padded final word: a design that does not clear its packing register leaks stale bytes into the upper lanes. A 64-byte read is left undrained long enough to fill the buffer, which shows whether the engine stalls or overwrites. Cancel during that stall, a second start mid-read and a zero-length start check that the control state machine neither restarts the command nor reports a false done.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADR,
    PH_MOD,
    PH_DUM,
    PH_DAT
  } fir_phase_e;

  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_ADDR  = 3'd1;
  localparam logic [2:0] IDX_COUNT = 3'd2;
  localparam logic [2:0] IDX_FMT   = 3'd3;
  localparam logic [2:0] IDX_MODE  = 3'd4;
  localparam logic [2:0] IDX_LEVEL = 3'd5;
  localparam logic [2:0] IDX_DATA  = 3'd6;

  localparam int CTL_START  = 0;
  localparam int CTL_CANCEL = 1;
  localparam int CTL_BUSY   = 2;
  localparam int CTL_DONE   = 5;

  localparam int FMT_W      = 18;
  localparam int FMT_LANE_L = 8;
  localparam int FMT_MODE   = 10;
  localparam int FMT_DUM_L  = 11;
  localparam int FMT_ALEN_L = 16;

endpackage

// File: rtl/fir_fifo.sv
module fir_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem_q[rptr_q];
  assign level   = cnt_q;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push_ok) wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_n = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (push && !flush) |-> !full); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n) (pop && empty && !push) |=> empty); // R12

endmodule

// File: rtl/fir_packer.sv
module fir_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  input  logic        byte_last,
  output logic        push,
  output logic [31:0] push_data
);

  logic [1:0]  idx_q, idx_n;
  logic [31:0] word_q, word_n, merged;

  always_comb begin
    merged = word_q;
    merged[{idx_q, 3'b000} +: 8] = byte_dat;
  end

  assign push      = byte_vld && !flush && (idx_q == 2'd3 || byte_last);
  assign push_data = merged;

  always_comb begin
    idx_n  = idx_q;
    word_n = word_q;
    if (flush) begin
      idx_n  = '0;
      word_n = '0;
    end else if (byte_vld) begin
      if (push) begin
        idx_n  = '0;
        word_n = '0;
      end else begin
        idx_n  = idx_q + 1'b1;
        word_n = merged;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      word_q <= '0;
    end else begin
      idx_q  <= idx_n;
      word_q <= word_n;
    end
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (push && byte_last && idx_q == 2'd0) |-> (push_data[31:8] == 24'h0)); // R5

endmodule

// File: rtl/fir_seq.sv
module fir_seq
  import fir_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [7:0]       opcode,
  input  logic [1:0]       lanes,
  input  logic             mode_en,
  input  logic [7:0]       mode_val,
  input  logic [4:0]       dummy,
  input  logic             addr4,
  input  logic [31:0]      addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             buf_full,
  input  logic [3:0]       io_in,
  output logic             sel,
  output logic             tick,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             byte_vld,
  output logic [7:0]       byte_dat,
  output logic             byte_last,
  output logic             finish
);

  fir_phase_e       state_q, state_n;
  logic [31:0]      shift_q, shift_n;
  logic [5:0]       cnt_q, cnt_n;
  logic [CNT_W-1:0] left_q, left_n;
  logic [7:0]       byte_q, byte_n, byte_shift;
  logic [5:0]       bpb;
  logic             last_beat, cmd_phase;

  always_comb begin
    case (lanes)
      2'd0:    bpb = 6'd8;
      2'd1:    bpb = 6'd4;
      default: bpb = 6'd2;
    endcase
  end

  always_comb begin
    case (lanes)
      2'd0:    byte_shift = {byte_q[6:0], io_in[1]};
      2'd1:    byte_shift = {byte_q[5:0], io_in[1:0]};
      default: byte_shift = {byte_q[3:0], io_in};
    endcase
  end

  assign last_beat = (cnt_q == 6'd1);
  assign cmd_phase = (state_q == PH_OPC) || (state_q == PH_ADR) || (state_q == PH_MOD);
  assign sel       = (state_q != PH_IDLE);
  assign tick      = cmd_phase || (state_q == PH_DUM) || (state_q == PH_DAT && !buf_full);
  assign io_out    = cmd_phase ? {3'b000, shift_q[31]} : 4'b0000;
  assign io_oe     = cmd_phase ? 4'b0001 : 4'b0000;
  assign byte_dat  = byte_shift;

  always_comb begin
    state_n   = state_q;
    shift_n   = shift_q;
    cnt_n     = cnt_q;
    left_n    = left_q;
    byte_n    = byte_q;
    byte_vld  = 1'b0;
    byte_last = 1'b0;
    finish    = 1'b0;
    if (cancel) begin
      state_n = PH_IDLE;
    end else begin
      case (state_q)
        PH_IDLE: begin
          if (start) begin
            if (byte_count == '0) begin
              finish = 1'b1;
            end else begin
              state_n = PH_OPC;
              shift_n = {opcode, 24'h0};
              cnt_n   = 6'd8;
              left_n  = byte_count;
            end
          end
        end
        PH_OPC: begin
          shift_n = {shift_q[30:0], 1'b0};
          cnt_n   = cnt_q - 1'b1;
          if (last_beat) begin
            state_n = PH_ADR;
            shift_n = addr4 ? addr : {addr[23:0], 8'h00};
            cnt_n   = addr4 ? 6'd32 : 6'd24;
          end
        end
        PH_ADR: begin
          shift_n = {shift_q[30:0], 1'b0};
          cnt_n   = cnt_q - 1'b1;
          if (last_beat) begin
            if (mode_en) begin
              state_n = PH_MOD;
              shift_n = {mode_val, 24'h0};
              cnt_n   = 6'd8;
            end else if (dummy != 5'd0) begin
              state_n = PH_DUM;
              cnt_n   = {1'b0, dummy};
            end else begin
              state_n = PH_DAT;
              cnt_n   = bpb;
            end
          end
        end
        PH_MOD: begin
          shift_n = {shift_q[30:0], 1'b0};
          cnt_n   = cnt_q - 1'b1;
          if (last_beat) begin
            if (dummy != 5'd0) begin
              state_n = PH_DUM;
              cnt_n   = {1'b0, dummy};
            end else begin
              state_n = PH_DAT;
              cnt_n   = bpb;
            end
          end
        end
        PH_DUM: begin
          cnt_n = cnt_q - 1'b1;
          if (last_beat) begin
            state_n = PH_DAT;
            cnt_n   = bpb;
          end
        end
        PH_DAT: begin
          if (tick) begin
            byte_n = byte_shift;
            cnt_n  = cnt_q - 1'b1;
            if (last_beat) begin
              byte_vld = 1'b1;
              cnt_n    = bpb;
              left_n   = left_q - 1'b1;
              if (left_q == CNT_W'(1)) begin
                byte_last = 1'b1;
                finish    = 1'b1;
                state_n   = PH_IDLE;
              end
            end
          end
        end
        default: state_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_n;
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      left_q  <= left_n;
      byte_q  <= byte_n;
    end
  end

  AST_OPC_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sel) |-> (io_oe == 4'b0001 && io_out[0] == opcode[7])); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == PH_DAT && buf_full && !cancel) |=> (sel && $stable(left_q))); // R7

endmodule

// File: rtl/flash_indirect_reader.sv
module flash_indirect_reader
  import fir_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int CNT_W     = 16,
  localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        flash_sel,
  output logic        flash_tick,
  output logic [3:0]  flash_io_out,
  output logic [3:0]  flash_io_oe,
  input  logic [3:0]  flash_io_in
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [31:0]      addr_q;
  logic [CNT_W-1:0] count_q;
  logic [FMT_W-1:0] fmt_q;
  logic [7:0]       mode_q;
  logic             done_q, done_n;
  logic             ctrl_wr, cancel, start, flush, busy, finish;
  logic             byte_vld, byte_last, push, pop, buf_full, buf_empty;
  logic [7:0]       byte_dat;
  logic [31:0]      push_data, head;
  logic [LVL_W-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign ctrl_wr = reg_we && (reg_addr == IDX_CTRL);
  assign cancel  = ctrl_wr && reg_wdata[CTL_CANCEL];
  assign start   = ctrl_wr && reg_wdata[CTL_START] && !reg_wdata[CTL_CANCEL] && !busy;
  assign flush   = cancel || start;
  assign pop     = reg_re && (reg_addr == IDX_DATA);
  assign busy    = flash_sel;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q  <= '0;
      count_q <= '0;
      fmt_q   <= '0;
      mode_q  <= '0;
    end else begin
      if (reg_we && reg_addr == IDX_ADDR)  addr_q  <= reg_wdata;
      if (reg_we && reg_addr == IDX_COUNT) count_q <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_addr == IDX_FMT)   fmt_q   <= reg_wdata[FMT_W-1:0];
      if (reg_we && reg_addr == IDX_MODE)  mode_q  <= reg_wdata[7:0];
    end
  end

  always_comb begin
    done_n = done_q;
    if (finish)                                     done_n = 1'b1;
    else if (start || cancel)                       done_n = 1'b0;
    else if (ctrl_wr && reg_wdata[CTL_DONE])        done_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) done_q <= 1'b0;
    else            done_q <= done_n;
  end

  always_comb begin
    case (reg_addr)
      IDX_CTRL:  reg_rdata = 32'(done_q) << CTL_DONE | 32'(busy) << CTL_BUSY;
      IDX_ADDR:  reg_rdata = addr_q;
      IDX_COUNT: reg_rdata = 32'(count_q);
      IDX_FMT:   reg_rdata = 32'(fmt_q);
      IDX_MODE:  reg_rdata = {24'h0, mode_q};
      IDX_LEVEL: reg_rdata = 32'(level);
      IDX_DATA:  reg_rdata = buf_empty ? 32'h0 : head;
      default:   reg_rdata = 32'h0;
    endcase
  end

  fir_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .cancel     (cancel),
    .opcode     (fmt_q[7:0]),
    .lanes      (fmt_q[FMT_LANE_L +: 2]),
    .mode_en    (fmt_q[FMT_MODE]),
    .mode_val   (mode_q),
    .dummy      (fmt_q[FMT_DUM_L +: 5]),
    .addr4      (fmt_q[FMT_ALEN_L +: 2] == 2'd3),
    .addr       (addr_q),
    .byte_count (count_q),
    .buf_full   (buf_full),
    .io_in      (flash_io_in),
    .sel        (flash_sel),
    .tick       (flash_tick),
    .io_out     (flash_io_out),
    .io_oe      (flash_io_oe),
    .byte_vld   (byte_vld),
    .byte_dat   (byte_dat),
    .byte_last  (byte_last),
    .finish     (finish)
  );

  fir_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .flush     (flush),
    .byte_vld  (byte_vld),
    .byte_dat  (byte_dat),
    .byte_last (byte_last),
    .push      (push),
    .push_data (push_data)
  );

  fir_fifo #(.DEPTH(BUF_DEPTH), .W(32)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .flush     (flush),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head      (head),
    .level     (level),
    .full      (buf_full),
    .empty     (buf_empty)
  );

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n_int) done_q |-> !busy); // R8
  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n_int) cancel |=> (!flash_sel && level == '0 && !done_q)); // R10
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n_int) (ctrl_wr && reg_wdata[CTL_DONE] && !finish) |=> !done_q); // R9

endmodule

// File: tb/tb_flash_indirect_reader.sv
module tb_flash_indirect_reader;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        flash_sel, flash_tick;
  logic [3:0]  flash_io_out, flash_io_oe;
  logic [3:0]  flash_io_in = 4'h0;

  int n_chk = 0;
  int n_fail = 0;

  int          m_lanes = 0;
  int          m_seed = 0;
  int          m_data_start = 1000;
  int          m_beat = 0;
  int          m_cmd_beats = 0;
  int          m_sel_rises = 0;
  bit          m_oe_bad = 1'b0;
  bit          m_prev_sel = 1'b0;
  logic [63:0] m_cap = 64'h0;

  always #4 clk = ~clk;

  flash_indirect_reader #(.BUF_DEPTH(DEPTH), .CNT_W(16)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .flash_sel    (flash_sel),
    .flash_tick   (flash_tick),
    .flash_io_out (flash_io_out),
    .flash_io_oe  (flash_io_oe),
    .flash_io_in  (flash_io_in)
  );

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 29 + seed * 7 + 3) & 255);
  endfunction

  function automatic logic [3:0] lane_val(input int beat);
    int j, bpb, k, p;
    logic [7:0] b;
    logic [3:0] v;
    if (beat < m_data_start) return 4'h0;
    j   = beat - m_data_start;
    bpb = (m_lanes == 0) ? 8 : (m_lanes == 1) ? 4 : 2;
    k   = j / bpb;
    p   = j % bpb;
    b   = pat(k, m_seed);
    if (m_lanes == 0)      v = {2'b11, b[7-p], ~b[7-p]};
    else if (m_lanes == 1) v = {2'b11, b[7-2*p], b[6-2*p]};
    else                   v = (p == 0) ? b[7:4] : b[3:0];
    return v;
  endfunction

  // flash device model: observes beats at the falling edge, drives the lanes
  initial begin
    forever begin
      @(negedge clk);
      if (flash_sel && !m_prev_sel) m_sel_rises++;
      m_prev_sel = flash_sel;
      if (flash_sel) begin
        if (flash_tick) begin
          if (flash_io_oe != 4'h0) begin
            m_cap = {m_cap[62:0], flash_io_out[0]};
            m_cmd_beats++;
            if (flash_io_oe != 4'b0001) m_oe_bad = 1'b1;
          end
          flash_io_in = lane_val(m_beat);
          m_beat++;
        end
      end else begin
        m_beat = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_re   = 1'b1;
    #1;
    d = reg_rdata;
    @(posedge clk);
    #1;
    reg_re = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input int w, input int n, input int seed);
    logic [31:0] r = 32'h0;
    for (int b = 0; b < 4; b++) begin
      if (4 * w + b < n) r[8*b +: 8] = pat(4 * w + b, seed);
    end
    return r;
  endfunction

  task automatic do_read(input logic [31:0] a, input int n, input int ln, input bit men,
                         input logic [7:0] mv, input int dum, input bit a4, input int seed,
                         input bit restart, input int stall_wait, input string req);
    logic [7:0]  op;
    logic [31:0] d;
    logic [63:0] e;
    int words, got, guard, ab;
    op    = 8'h6B ^ 8'(seed);
    ab    = a4 ? 4 : 3;
    m_lanes = ln;
    m_seed  = seed;
    m_data_start = 8 + ab * 8 + (men ? 8 : 0) + dum;
    m_cap = 64'h0;
    m_cmd_beats = 0;
    m_oe_bad = 1'b0;
    m_sel_rises = 0;
    wr(3'd1, a);
    wr(3'd2, 32'(n));
    wr(3'd3, {14'h0, (a4 ? 2'd3 : 2'd2), 5'(dum), men, 2'(ln), op});
    wr(3'd4, {24'h0, mv});
    wr(3'd0, 32'h1);
    rd(3'd0, d);
    chk(d[2] == 1'b1, {req, " R8 busy while running"}, 64'(d), 64'h4);
    if (restart) wr(3'd0, 32'h1);
    if (stall_wait > 0) begin
      repeat (stall_wait) @(posedge clk);
      rd(3'd5, d);
      chk(d == 32'(DEPTH), "R7 level at full", 64'(d), 64'(DEPTH));
      @(negedge clk);
      #1;
      chk(flash_sel && !flash_tick, "R7 stalled beat strobe", 64'({flash_sel, flash_tick}), 64'h2);
    end
    words = (n + 3) / 4;
    got = 0;
    guard = 0;
    while (got < words && guard < 20000) begin
      rd(3'd5, d);
      if (d != 32'h0) begin
        rd(3'd6, d);
        chk(d == exp_word(got, n, seed), {req, " R5 R6 word"}, 64'(d), 64'(exp_word(got, n, seed)));
        got++;
      end
      guard++;
    end
    chk(got == words, {req, " R6 words drained"}, 64'(got), 64'(words));
    guard = 0;
    d = 32'h0;
    while (!d[5] && guard < 200) begin
      rd(3'd0, d);
      guard++;
    end
    chk(d == 32'h20, {req, " R8 done and idle"}, 64'(d), 64'h20);
    rd(3'd5, d);
    chk(d == 32'h0, {req, " R6 level empty"}, 64'(d), 64'h0);
    e = 64'(op);
    e = (e << (ab * 8)) | 64'(a4 ? a : {8'h0, a[23:0]});
    if (men) e = (e << 8) | 64'(mv);
    chk(m_cmd_beats == 8 + ab * 8 + (men ? 8 : 0), {req, " R2 R3 command beat count"},
        64'(m_cmd_beats), 64'(8 + ab * 8 + (men ? 8 : 0)));
    chk(m_cap == e, {req, " R2 R3 command bits"}, m_cap, e);
    chk(!m_oe_bad, {req, " R2 lane 0 only"}, 64'(m_oe_bad), 64'h0);
    chk(m_sel_rises == 1, {req, " R11 one command issued"}, 64'(m_sel_rises), 64'h1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(!flash_sel && !flash_tick, "R1 select and strobe low", 64'({flash_sel, flash_tick}), 64'h0);
    rd(3'd0, d);
    chk(d == 32'h0, "R1 control word", 64'(d), 64'h0);
    rd(3'd5, d);
    chk(d == 32'h0, "R1 level word", 64'(d), 64'h0);
  endtask

  task automatic t_empty_read;
    logic [31:0] d;
    rd(3'd6, d);
    chk(d == 32'h0, "R12 empty data port", 64'(d), 64'h0);
    rd(3'd5, d);
    chk(d == 32'h0, "R12 level after empty pop", 64'(d), 64'h0);
  endtask

  task automatic t_done_w1c;
    logic [31:0] d;
    wr(3'd0, 32'h0);
    rd(3'd0, d);
    chk(d == 32'h20, "R9 done kept on zero write", 64'(d), 64'h20);
    wr(3'd0, 32'h20);
    rd(3'd0, d);
    chk(d == 32'h0, "R9 done cleared", 64'(d), 64'h0);
  endtask

  task automatic t_cancel;
    logic [31:0] d;
    m_lanes = 0;
    m_seed = 9;
    m_data_start = 32;
    wr(3'd1, 32'h0001_2000);
    wr(3'd2, 32'd64);
    wr(3'd3, {14'h0, 2'd2, 5'd0, 1'b0, 2'd0, 8'h03});
    wr(3'd0, 32'h1);
    repeat (320) @(posedge clk);
    wr(3'd0, 32'h2);
    chk(!flash_sel, "R10 select drops after cancel", 64'(flash_sel), 64'h0);
    rd(3'd0, d);
    chk(d == 32'h0, "R10 not busy not done", 64'(d), 64'h0);
    rd(3'd5, d);
    chk(d == 32'h0, "R10 buffer emptied", 64'(d), 64'h0);
  endtask

  task automatic t_zero_len;
    logic [31:0] d;
    m_sel_rises = 0;
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h1);
    rd(3'd0, d);
    chk(d == 32'h20, "R11 zero count done", 64'(d), 64'h20);
    chk(m_sel_rises == 0, "R11 zero count no select", 64'(m_sel_rises), 64'h0);
    wr(3'd0, 32'h20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_empty_read();
    do_read(32'h00AB_CDEF, 7, 0, 1'b0, 8'h00, 0, 1'b0, 1, 1'b0, 0, "single R4");
    t_done_w1c();
    do_read(32'h1234_5678, 12, 1, 1'b1, 8'hA5, 6, 1'b1, 2, 1'b0, 0, "dual mode R3");
    do_read(32'h0000_0100, 5, 2, 1'b0, 8'h00, 8, 1'b0, 3, 1'b1, 0, "quad restart R11");
    do_read(32'h00FF_FFFC, 1, 3, 1'b1, 8'h00, 0, 1'b1, 4, 1'b0, 0, "one byte R5");
    do_read(32'h0040_0000, 64, 0, 1'b0, 8'h00, 0, 1'b0, 5, 1'b0, 400, "stall R7");
    t_cancel();
    t_zero_len();
    t_empty_read();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule